// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

This block gathers up to thirty-two external interrupt lines. It turns them into two request outputs toward a processor: one of normal class and one of urgent class. Software reaches it through a word-wide register port with an address, a write strobe, a read strobe and a data bus. Each line has its own settings. A trigger bit picks edge or level sensing. A polarity bit picks rising or high (1), or falling or low (0). A class bit routes the line to the urgent output. An enable bit lets the line reach either output. A captured pending bit for each line is cleared by writing a one to it.

Software can read a view of the pending bits gated by the enables. It can also read one register that gives the number of the winning pending line, together with a valid flag. Line n always sits at bit 31-n, so line 0 is the most significant bit and has the highest priority. The raw lines pass through a two-flop synchronizer. The synchronizer comes out of reset holding the idle-high value, which matches the default active-low level sensing.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable (0x2), class (0x3), polarity (0x4) and trigger (0x5) registers read zero, the status register (0x0) reads zero, and both outputs are low, provided the lines are held high.
- R2: Source n maps to bit 31-n of every per-source register, and also of `irq_lines`.
- R3: Writing the status register at 0x0 clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R4: With trigger bit 1, a pending bit is set on a rising transition when polarity is 1, or on a falling transition when polarity is 0. The opposite transition does not set it. Once set, the bit stays set after the line returns, until software clears it.
- R5: With trigger bit 0, a pending bit is set while the line is at the active level (high when polarity is 1, low when polarity is 0). A clear has no effect while that level persists. Once the line is inactive, a clear takes effect.
- R6: The masked status register at 0x6 reads the status bits ANDed with the enable bits. Status itself is unaffected by the enables.
- R7: The pending register at 0x9 holds a valid flag in bit 5 and a source number in bits 4:0. The number is that of the lowest-numbered enabled pending source, which is the most significant set bit of masked status. The register reads 0 when no enabled source is pending.
- R8: `irq_crit` is the registered OR of masked status bits whose class bit is 1. `irq_noncrit` is the registered OR of those whose class bit is 0.
- R9: Offsets 0x7, 0x8, 0x1 and 0xA to 0xF read zero. Writes to them change no register.
- R10: A read loads `rdata` on the clock edge at which `rd_en` is high, and `rdata` holds its value otherwise. The enable, class, polarity and trigger registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_lines | input | 32 | Raw interrupt lines, source n on bit 31-n |
| irq_noncrit | output | 1 | Normal-class request |
| irq_crit | output | 1 | Urgent-class request |

## Verification
Each sensing mode is driven with both transitions of its line. This shows that a rising-edge source ignores a falling edge, and that a captured edge outlives its pulse. A level source is cleared while its level is still asserted and again after it drops, which separates the sticky level behaviour from plain write-one-to-clear. Enable and class patterns with two pending sources show that masking, routing and priority use the correct bits. Sources 0 and 31 then pin down the ends of the priority order and of the bit reversal.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'h0;
  localparam logic [REG_AW-1:0] OFS_ENAB  = 4'h2;
  localparam logic [REG_AW-1:0] OFS_CLASS = 4'h3;
  localparam logic [REG_AW-1:0] OFS_POLAR = 4'h4;
  localparam logic [REG_AW-1:0] OFS_TRIG  = 4'h5;
  localparam logic [REG_AW-1:0] OFS_MSTAT = 4'h6;
  localparam logic [REG_AW-1:0] OFS_VEC   = 4'h7;
  localparam logic [REG_AW-1:0] OFS_VCFG  = 4'h8;
  localparam logic [REG_AW-1:0] OFS_PEND  = 4'h9;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= INIT;
      hold_q <= INIT;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_s,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] polar,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] prev_q, set_now, stat_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= line_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic act_now, act_old;
    assign act_now    = (line_s[i] == polar[i]);
    assign act_old    = (prev_q[i] == polar[i]);
    assign set_now[i] = trig[i] ? (act_now & ~act_old) : act_now;

    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= set_now[i] | (stat_q[i] & ~clr[i]);
    end
  end

  assign stat = stat_q;

  // R3: a cleared bit with no new event is low on the next cycle
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (|clr) |=> ((stat_q & $past(clr & ~set_now)) == '0));

  // R4 and R5: an event always wins over a clear in the same cycle
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|set_now) |=> ((stat_q & $past(set_now)) == $past(set_now)));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N = 32,
  localparam int unsigned SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     masked,
  output logic [SEL_W-1:0] num,
  output logic             valid
);
  always_comb begin
    valid = 1'b0;
    num   = '0;
    for (int i = 0; i < N; i++) begin
      if (masked[i]) begin
        valid = 1'b1;
        num   = SEL_W'(N - 1 - i);
      end
    end
  end

  assert_win_set_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> masked[(N - 1) - int'(num)]);

  assert_win_top_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((masked >> (N - int'(num))) == '0));

  assert_none_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (masked == '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter logic [NUM_SRC-1:0] LINE_IDLE = '1,
  localparam int unsigned SEL_W = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] irq_lines,
  output logic              irq_noncrit,
  output logic              irq_crit
);
  logic [NUM_SRC-1:0] enab_q, class_q, polar_q, trig_q;
  logic [NUM_SRC-1:0] line_s, stat, clr, masked;
  logic [SEL_W-1:0]   win_num;
  logic               win_valid;
  logic [DATA_W-1:0]  rd_mux;

  irq_sync #(.W(NUM_SRC), .INIT(LINE_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(irq_lines), .q(line_s)
  );

  assign clr = (wr_en && addr == OFS_STAT) ? wdata[NUM_SRC-1:0] : '0;

  irq_sense #(.N(NUM_SRC), .INIT(LINE_IDLE)) u_sense (
    .clk(clk), .rst(rst), .line_s(line_s), .trig(trig_q),
    .polar(polar_q), .clr(clr), .stat(stat)
  );

  assign masked = stat & enab_q;

  irq_prio #(.N(NUM_SRC)) u_prio (
    .clk(clk), .rst(rst), .masked(masked), .num(win_num), .valid(win_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enab_q  <= '0;
      class_q <= '0;
      polar_q <= '0;
      trig_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ENAB:  enab_q  <= wdata[NUM_SRC-1:0];
        OFS_CLASS: class_q <= wdata[NUM_SRC-1:0];
        OFS_POLAR: polar_q <= wdata[NUM_SRC-1:0];
        OFS_TRIG:  trig_q  <= wdata[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_STAT:  rd_mux = DATA_W'(stat);
      OFS_ENAB:  rd_mux = DATA_W'(enab_q);
      OFS_CLASS: rd_mux = DATA_W'(class_q);
      OFS_POLAR: rd_mux = DATA_W'(polar_q);
      OFS_TRIG:  rd_mux = DATA_W'(trig_q);
      OFS_MSTAT: rd_mux = DATA_W'(masked);
      OFS_PEND:  rd_mux = DATA_W'({win_valid, win_num});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      irq_noncrit <= 1'b0;
      irq_crit    <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq_noncrit <= |(masked & ~class_q);
      irq_crit    <= |(masked & class_q);
    end
  end

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (enab_q == '0) |=> (!irq_noncrit && !irq_crit));

  assert_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == OFS_VEC || addr == OFS_VCFG || addr == OFS_MSTAT || addr == OFS_PEND))
    |=> ($stable(enab_q) && $stable(class_q) && $stable(polar_q) && $stable(trig_q)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] lines = '1;
  logic        irq_noncrit, irq_crit;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_lines(lines),
    .irq_noncrit(irq_noncrit), .irq_crit(irq_crit)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  req;
    logic [3:0]  a;
    logic [31:0] d;
  } op_t;

  localparam int NOPS = 22;
  localparam op_t TBL [NOPS] = '{
    '{1'b0, 4'd10, 4'h2, 32'hA5A5_0F0F},
    '{1'b1, 4'd10, 4'h2, 32'hA5A5_0F0F}, // R10 enable readback
    '{1'b0, 4'd10, 4'h3, 32'h0000_FFFF},
    '{1'b1, 4'd10, 4'h3, 32'h0000_FFFF}, // R10 class readback
    '{1'b0, 4'd10, 4'h5, 32'h8000_0001},
    '{1'b1, 4'd10, 4'h5, 32'h8000_0001}, // R10 trigger readback
    '{1'b0, 4'd10, 4'h4, 32'h8000_0001},
    '{1'b1, 4'd10, 4'h4, 32'h8000_0001}, // R10 polarity readback
    '{1'b0, 4'd9,  4'h7, 32'hFFFF_FFFF},
    '{1'b1, 4'd9,  4'h7, 32'h0},         // R9 vector reads zero
    '{1'b0, 4'd9,  4'h8, 32'h1234_5678},
    '{1'b1, 4'd9,  4'h8, 32'h0},         // R9 vector config reads zero
    '{1'b0, 4'd9,  4'hB, 32'hFFFF_FFFF},
    '{1'b1, 4'd9,  4'hB, 32'h0},         // R9 unused reads zero
    '{1'b1, 4'd9,  4'h1, 32'h0},         // R9 unused reads zero
    '{1'b1, 4'd9,  4'h2, 32'hA5A5_0F0F}, // R9 enable untouched
    '{1'b1, 4'd9,  4'h0, 32'h0},         // R9 status untouched
    '{1'b0, 4'd10, 4'h4, 32'h0},
    '{1'b0, 4'd10, 4'h5, 32'h0},
    '{1'b0, 4'd10, 4'h2, 32'h0},
    '{1'b0, 4'd10, 4'h3, 32'h0},
    '{1'b1, 4'd6,  4'h6, 32'h0}          // R6 nothing masked
  };

  function automatic logic [31:0] sb(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1 reset state
    rd(4'h0, v); check("R1", "status", v, 32'h0);
    rd(4'h2, v); check("R1", "enable", v, 32'h0);
    rd(4'h3, v); check("R1", "class", v, 32'h0);
    rd(4'h4, v); check("R1", "polarity", v, 32'h0);
    rd(4'h5, v); check("R1", "trigger", v, 32'h0);
    check("R1", "outputs", {30'h0, irq_noncrit, irq_crit}, 32'h0);

    for (int k = 0; k < NOPS; k++) begin
      if (TBL[k].rd) begin
        rd(TBL[k].a, v);
        check($sformatf("R%0d", TBL[k].req), $sformatf("table %0d", k), v, TBL[k].d);
      end else begin
        wr(TBL[k].a, TBL[k].d);
      end
    end

    // R4 rising edge on source 3
    wr(4'h5, sb(3)); wr(4'h4, sb(3));
    lines[28] = 1'b0; settle();
    rd(4'h0, v); check("R4", "falling ignored in rising mode", v, 32'h0);
    lines[28] = 1'b1; settle();
    rd(4'h0, v); check("R4", "rising captured", v, sb(3));
    lines[28] = 1'b0; settle();
    rd(4'h0, v); check("R4", "edge held after line drops", v, sb(3));
    wr(4'h0, ~sb(3));
    rd(4'h0, v); check("R3", "zero bit leaves status", v, sb(3));
    wr(4'h0, sb(3));
    rd(4'h0, v); check("R3", "one bit clears status", v, 32'h0);
    wr(4'h4, 32'h0); lines[28] = 1'b1; settle(); wr(4'h5, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R3", "clear all", v, 32'h0);

    // R4 falling edge on source 31
    wr(4'h5, sb(31));
    lines[0] = 1'b0; settle();
    rd(4'h0, v); check("R4", "falling captured", v, sb(31));
    lines[0] = 1'b1; settle();
    rd(4'h0, v); check("R4", "falling held", v, sb(31));
    wr(4'h0, sb(31)); wr(4'h5, 32'h0);
    rd(4'h0, v); check("R3", "falling cleared", v, 32'h0);

    // R5 level high on source 10
    wr(4'h4, sb(10)); settle();
    rd(4'h0, v); check("R5", "high level sets", v, sb(10));
    wr(4'h0, sb(10)); settle();
    rd(4'h0, v); check("R5", "clear blocked while active", v, sb(10));
    lines[21] = 1'b0; settle();
    wr(4'h0, sb(10));
    rd(4'h0, v); check("R5", "clear after inactive", v, 32'h0);
    lines[21] = 1'b1; settle(); wr(4'h4, 32'h0); wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R5", "restored", v, 32'h0);

    // R6 R7 R8 masking, priority, routing
    lines[26] = 1'b0; lines[11] = 1'b0;
    wr(4'h2, sb(5) | sb(20) | sb(26)); wr(4'h3, sb(20)); settle();
    rd(4'h6, v); check("R6", "masked two", v, sb(5) | sb(20));
    rd(4'h9, v); check("R7", "winner source 5", v, 32'h25);
    check("R8", "both outputs", {30'h0, irq_noncrit, irq_crit}, 32'h3);
    wr(4'h2, sb(20)); settle();
    rd(4'h6, v); check("R6", "masked one", v, sb(20));
    rd(4'h9, v); check("R7", "winner source 20", v, 32'h34);
    check("R8", "urgent only", {30'h0, irq_noncrit, irq_crit}, 32'h1);
    wr(4'h3, 32'h0); settle();
    check("R8", "normal only", {30'h0, irq_noncrit, irq_crit}, 32'h2);
    wr(4'h2, 32'h0); settle();
    rd(4'h9, v); check("R7", "none pending", v, 32'h0);
    rd(4'h0, v); check("R6", "status kept under mask", v, sb(5) | sb(20));
    check("R8", "outputs idle", {30'h0, irq_noncrit, irq_crit}, 32'h0);

    // R2 R7 boundary sources 0 and 31
    lines[31] = 1'b0; lines[0] = 1'b0;
    wr(4'h2, sb(31)); settle();
    rd(4'h9, v); check("R7", "winner source 31", v, 32'h3F);
    wr(4'h2, 32'hFFFF_FFFF); settle();
    rd(4'h9, v); check("R7", "winner source 0", v, 32'h20);
    rd(4'h0, v); check("R2", "bit reversal", v, 32'h8400_0801);
    check("R8", "normal raised", {30'h0, irq_noncrit, irq_crit}, 32'h2);

    finish_run();
  end
endmodule